// File: doc/BRIEF.md
# Two-Level Bound Table Walker

This block fetches and stores pointer bounds held in memory-resident tables for a pointer bounds checking unit. A request carries a linear base address, a pointer value, a width mode (64-bit or 32-bit), the current privilege level, two bound values for stores, and two configuration words, one for user code and one for supervisor code. The walker picks a configuration word by privilege, forms the address of a directory entry and reads it. If the entry is valid, it forms the address of a three-word table entry. A load reads the three words. A store writes them.

A load returns a lower and an upper bound. If the pointer stored in the table entry does not equal the requested pointer, both bounds come back as zero. If the directory entry is not valid, the walk stops. A one-cycle fault pulse then coincides with a status register that holds the directory entry address with bit 1 set. All memory traffic goes through a single request/response port that carries one access at a time.

Top module: `bnd_walker`

## Requirements
- R1: The configuration word used for the walk is `cfgUser` when `reqCpl` equals 3, and `cfgSuper` for any other privilege level.
- R2: With `reqMode64`=1, the first access is an 8-byte read (`memReqWide`=1) at address (base[47:20] << 3) + (cfg[63:20] << 12), taken modulo 2^64.
- R3: With `reqMode64`=0, the first access is a 4-byte read (`memReqWide`=0) at the 32-bit address (base[31:12] << 2) + (cfg with bits [11:0] cleared), zero-extended to 64 bits.
- R4: When bit 0 of the directory word read is 0, the walk makes no further memory access. `fault` pulses for one cycle, `done` stays low, and in that same cycle `status` shows the directory entry address ORed with 2.
- R5: In 64-bit mode, table field k (k = 0, 1, 2) is accessed at (base[19:3] << 5) + (directory word with bits [2:0] cleared) + 8*k, and each access is 8 bytes wide.
- R6: In 32-bit mode, table field k is accessed at the 32-bit address (base[11:2] << 4) + (directory word bits [31:0] with bits [1:0] cleared) + 4*k, and each access is 4 bytes wide. Only bits [31:0] of memory data and of the pointer take part in the walk.
- R7: A load performs reads of fields 0, 1 and 2 in that order. When field 2 equals the requested pointer, `lowerOut` and `upperOut` carry fields 0 and 1 while `done` is high.
- R8: When the stored pointer differs from the requested pointer on a load, `lowerOut` and `upperOut` are both zero while `done` is high.
- R9: A store writes `reqLower` to field 0, then `reqUpper` to field 1, then `reqPtr` to field 2.
- R10: Only one memory access is outstanding at a time. While `memReqValid` is high and `memReqReady` is low, the request stays asserted with unchanged address, direction and data.
- R11: `busy` is high in the cycle after a request is accepted and stays high until `done` or `fault` rises. `done` and `fault` are single-cycle pulses and never high together.
- R12: Synchronous reset returns the walker to idle (`reqReady`=1, `busy`=0), clears `status`, and holds `done`, `fault` and `memReqValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Walk request present |
| reqReady | output | 1 | Walker idle; request accepted when valid and ready |
| reqStore | input | 1 | 1 = bound store, 0 = bound load |
| reqMode64 | input | 1 | 1 = 64-bit layout, 0 = 32-bit layout |
| reqCpl | input | 2 | Current privilege level |
| reqBase | input | 64 | Linear base address used for table indexing |
| reqPtr | input | 64 | Pointer value compared on load, written on store |
| reqLower | input | 64 | Lower bound to store |
| reqUpper | input | 64 | Upper bound to store |
| cfgUser | input | 64 | Configuration word for privilege level 3 |
| cfgSuper | input | 64 | Configuration word for privilege levels 0 to 2 |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse, walk finished |
| fault | output | 1 | One-cycle pulse, directory entry invalid |
| lowerOut | output | 64 | Returned lower bound, valid with done after a load |
| upperOut | output | 64 | Returned upper bound, valid with done after a load |
| status | output | 64 | Fault status: directory entry address ORed with 2 |
| memReqValid | output | 1 | Memory access request |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWrite | output | 1 | 1 = write, 0 = read |
| memReqWide | output | 1 | 1 = 8-byte access, 0 = 4-byte access |
| memReqAddr | output | 64 | Byte address of the access |
| memReqWdata | output | 64 | Write data |
| memRspValid | input | 1 | Response for the outstanding access (read data or write ack) |
| memRspData | input | 64 | Read data |

## Verification
The bench builds the walker with its default 64-bit address and data widths, because the slicing of the table indices is tied to fixed bit positions. It sweeps every pair of width mode and privilege level across five request kinds: load with a matching pointer, load with a mismatched pointer, store, invalid directory entry, and a pointer that differs only in bits 63:32. The last kind is a match in 32-bit mode and a mismatch in 64-bit mode. A bench memory model inserts 0 to 2 cycles of ready stall and records every access, so each directory and table address, each access width, the write order and the returned bounds can be compared with values the bench computes from shifts and masks.

// File: rtl/bw_pkg.sv
package bw_pkg;

  localparam int ADDR_W   = 64;
  localparam int DATA_W   = 64;
  localparam int HALF_W   = 32;
  localparam int CPL_W    = 2;
  localparam int FIELD_N  = 3;
  localparam int IDX_W    = 2;
  localparam logic [CPL_W-1:0] CPL_USER = 2'd3;

  // Field index sequence for table entry accesses; order is behaviour
  localparam logic [IDX_W-1:0] IDX_LOWER = 2'd0;
  localparam logic [IDX_W-1:0] IDX_UPPER = 2'd1;
  localparam logic [IDX_W-1:0] IDX_PTR   = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_ENT_REQ,
    ST_ENT_WAIT,
    ST_DONE,
    ST_FAULT
  } walkState_t;

  typedef struct packed {
    logic             capture;    // latch request fields
    logic             dirPhase;   // address mux selects directory address
    logic [IDX_W-1:0] fieldIdx;   // table entry field being accessed
    logic             dirLoad;    // latch directory word
    logic             fieldLoad;  // latch a table field read
    logic             setStatus;  // load fault status
    logic             finish;     // resolve returned bounds
  } walkStrobe_t;

endpackage

// File: rtl/bw_ctrl.sv
module bw_ctrl
  import bw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        reqStore,
  output logic        reqReady,
  output logic        busy,
  output logic        done,
  output logic        fault,
  output logic        memReqValid,
  input  logic        memReqReady,
  output logic        memReqWrite,
  input  logic        memRspValid,
  input  logic        dirValid,
  output walkStrobe_t strobe
);

  walkState_t       state, stateNext;
  logic             storeOp;
  logic [IDX_W-1:0] idx, idxNext;

  always_comb begin
    stateNext        = state;
    idxNext          = idx;
    strobe           = '0;
    strobe.fieldIdx  = idx;
    memReqValid      = 1'b0;
    memReqWrite      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          stateNext      = ST_DIR_REQ;
        end
      end
      ST_DIR_REQ: begin
        strobe.dirPhase = 1'b1;
        memReqValid     = 1'b1;
        if (memReqReady) stateNext = ST_DIR_WAIT;
      end
      ST_DIR_WAIT: begin
        strobe.dirPhase = 1'b1;
        if (memRspValid) begin
          if (dirValid) begin
            strobe.dirLoad = 1'b1;
            idxNext        = IDX_LOWER;
            stateNext      = ST_ENT_REQ;
          end else begin
            strobe.setStatus = 1'b1;
            stateNext        = ST_FAULT;
          end
        end
      end
      ST_ENT_REQ: begin
        memReqValid = 1'b1;
        memReqWrite = storeOp;
        if (memReqReady) stateNext = ST_ENT_WAIT;
      end
      ST_ENT_WAIT: begin
        if (memRspValid) begin
          strobe.fieldLoad = !storeOp;
          if (idx == IDX_PTR) begin
            strobe.finish = !storeOp;
            stateNext     = ST_DONE;
          end else begin
            idxNext   = idx + 1'b1;
            stateNext = ST_ENT_REQ;
          end
        end
      end
      ST_DONE:  stateNext = ST_IDLE;
      ST_FAULT: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      idx     <= IDX_LOWER;
      storeOp <= 1'b0;
    end else begin
      state <= stateNext;
      idx   <= idxNext;
      if (strobe.capture) storeOp <= reqStore;
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign busy     = (state == ST_DIR_REQ) || (state == ST_DIR_WAIT) ||
                    (state == ST_ENT_REQ) || (state == ST_ENT_WAIT);
  assign done     = (state == ST_DONE);
  assign fault    = (state == ST_FAULT);

  a_r11_busy_on_accept: assert property (@(posedge clk) disable iff (rst)
    reqValid && reqReady |=> busy);

  a_r11_pulse_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));

  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !busy);

  a_r4_no_access_after_fault: assert property (@(posedge clk) disable iff (rst)
    fault |=> !memReqValid);

  a_r9_store_writes_fields: assert property (@(posedge clk) disable iff (rst)
    memReqValid && !strobe.dirPhase |-> memReqWrite == storeOp);

  a_r7_three_fields: assert property (@(posedge clk) disable iff (rst)
    memReqValid && !strobe.dirPhase |-> idx < IDX_W'(FIELD_N));

endmodule

// File: rtl/bw_dpath.sv
module bw_dpath
  import bw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  walkStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [DATA_W-1:0] reqPtr,
  input  logic [DATA_W-1:0] reqLower,
  input  logic [DATA_W-1:0] reqUpper,
  input  logic              reqMode64,
  input  logic [CPL_W-1:0]  reqCpl,
  input  logic [DATA_W-1:0] cfgUser,
  input  logic [DATA_W-1:0] cfgSuper,
  input  logic [DATA_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              memReqWide,
  output logic [DATA_W-1:0] memReqWdata,
  output logic              dirValid,
  output logic [DATA_W-1:0] lowerOut,
  output logic [DATA_W-1:0] upperOut,
  output logic [ADDR_W-1:0] status
);

  localparam int PAD_W = ADDR_W - HALF_W;

  logic [ADDR_W-1:0] baseReg;
  logic [DATA_W-1:0] ptrReg, lowerReg, upperReg, cfgReg, dirReg;
  logic [DATA_W-1:0] rdLower, rdUpper;
  logic              wideReg;

  logic [ADDR_W-1:0] dirAddrWide, entAddrWide, dirAddrSel;
  logic [HALF_W-1:0] dirAddrNarrow, entAddrNarrow;
  logic [DATA_W-1:0] rspWord, ptrCmp;
  logic              ptrMatch;

  // Directory entry address, 64-bit layout
  assign dirAddrWide = ADDR_W'({baseReg[47:20], 3'b000}) +
                       ADDR_W'({cfgReg[63:20], 12'h000});

  // Table entry address, 64-bit layout
  assign entAddrWide = ADDR_W'({baseReg[19:3], 5'b00000}) +
                       {dirReg[63:3], 3'b000} +
                       ADDR_W'({strobe.fieldIdx, 3'b000});

  // Directory entry address, 32-bit layout
  assign dirAddrNarrow = HALF_W'({baseReg[31:12], 2'b00}) +
                         {cfgReg[31:12], 12'h000};

  // Table entry address, 32-bit layout
  assign entAddrNarrow = HALF_W'({baseReg[11:2], 4'b0000}) +
                         {dirReg[31:2], 2'b00} +
                         HALF_W'({strobe.fieldIdx, 2'b00});

  assign dirAddrSel = wideReg ? dirAddrWide : {{PAD_W{1'b0}}, dirAddrNarrow};

  always_comb begin
    if (strobe.dirPhase) memReqAddr = dirAddrSel;
    else if (wideReg)    memReqAddr = entAddrWide;
    else                 memReqAddr = {{PAD_W{1'b0}}, entAddrNarrow};
  end

  assign memReqWide = wideReg;

  always_comb begin
    unique case (strobe.fieldIdx)
      IDX_LOWER: memReqWdata = lowerReg;
      IDX_UPPER: memReqWdata = upperReg;
      default:   memReqWdata = ptrReg;
    endcase
  end

  assign rspWord  = wideReg ? memRspData : {{PAD_W{1'b0}}, memRspData[HALF_W-1:0]};
  assign dirValid = memRspData[0];
  assign ptrCmp   = ptrReg;
  assign ptrMatch = (rspWord == ptrCmp);

  logic unusedBits;
  assign unusedBits = ^{baseReg[63:48], baseReg[2:0], cfgReg[11:0], dirReg[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      baseReg  <= '0;
      ptrReg   <= '0;
      lowerReg <= '0;
      upperReg <= '0;
      cfgReg   <= '0;
      dirReg   <= '0;
      wideReg  <= 1'b0;
      rdLower  <= '0;
      rdUpper  <= '0;
      lowerOut <= '0;
      upperOut <= '0;
      status   <= '0;
    end else begin
      if (strobe.capture) begin
        baseReg <= reqBase;
        wideReg <= reqMode64;
        cfgReg  <= (reqCpl == CPL_USER) ? cfgUser : cfgSuper;
        if (reqMode64) begin
          ptrReg   <= reqPtr;
          lowerReg <= reqLower;
          upperReg <= reqUpper;
        end else begin
          ptrReg   <= {{PAD_W{1'b0}}, reqPtr[HALF_W-1:0]};
          lowerReg <= {{PAD_W{1'b0}}, reqLower[HALF_W-1:0]};
          upperReg <= {{PAD_W{1'b0}}, reqUpper[HALF_W-1:0]};
        end
      end
      if (strobe.dirLoad) dirReg <= rspWord;
      if (strobe.fieldLoad) begin
        if (strobe.fieldIdx == IDX_LOWER) rdLower <= rspWord;
        if (strobe.fieldIdx == IDX_UPPER) rdUpper <= rspWord;
      end
      if (strobe.finish) begin
        lowerOut <= ptrMatch ? rdLower : '0;
        upperOut <= ptrMatch ? rdUpper : '0;
      end
      if (strobe.setStatus) status <= dirAddrSel | ADDR_W'(2);
    end
  end

  a_r1_user_cfg: assert property (@(posedge clk) disable iff (rst)
    strobe.capture && reqCpl == CPL_USER |=> cfgReg == $past(cfgUser));

  a_r1_super_cfg: assert property (@(posedge clk) disable iff (rst)
    strobe.capture && reqCpl != CPL_USER |=> cfgReg == $past(cfgSuper));

  a_r4_status_flag: assert property (@(posedge clk) disable iff (rst)
    strobe.setStatus |=> status[1]);

  a_r8_mismatch_zero: assert property (@(posedge clk) disable iff (rst)
    strobe.finish && !ptrMatch |=> lowerOut == '0 && upperOut == '0);

  a_r12_reset_clear: assert property (@(posedge clk)
    rst |=> status == '0 && lowerOut == '0 && upperOut == '0);

endmodule

// File: rtl/bnd_walker.sv
module bnd_walker
  import bw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqStore,
  input  logic              reqMode64,
  input  logic [CPL_W-1:0]  reqCpl,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [DATA_W-1:0] reqPtr,
  input  logic [DATA_W-1:0] reqLower,
  input  logic [DATA_W-1:0] reqUpper,
  input  logic [DATA_W-1:0] cfgUser,
  input  logic [DATA_W-1:0] cfgSuper,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [DATA_W-1:0] lowerOut,
  output logic [DATA_W-1:0] upperOut,
  output logic [ADDR_W-1:0] status,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic              memReqWide,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqWdata,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData
);

  walkStrobe_t strobe;
  logic        dirValid;

  bw_ctrl i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .reqValid    (reqValid),
    .reqStore    (reqStore),
    .reqReady    (reqReady),
    .busy        (busy),
    .done        (done),
    .fault       (fault),
    .memReqValid (memReqValid),
    .memReqReady (memReqReady),
    .memReqWrite (memReqWrite),
    .memRspValid (memRspValid),
    .dirValid    (dirValid),
    .strobe      (strobe)
  );

  bw_dpath i_dpath (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .reqBase     (reqBase),
    .reqPtr      (reqPtr),
    .reqLower    (reqLower),
    .reqUpper    (reqUpper),
    .reqMode64   (reqMode64),
    .reqCpl      (reqCpl),
    .cfgUser     (cfgUser),
    .cfgSuper    (cfgSuper),
    .memRspData  (memRspData),
    .memReqAddr  (memReqAddr),
    .memReqWide  (memReqWide),
    .memReqWdata (memReqWdata),
    .dirValid    (dirValid),
    .lowerOut    (lowerOut),
    .upperOut    (upperOut),
    .status      (status)
  );

  a_r10_hold_request: assert property (@(posedge clk) disable iff (rst)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr) &&
                                    $stable(memReqWrite) && $stable(memReqWdata));

  a_r12_idle_after_reset: assert property (@(posedge clk)
    rst |=> reqReady && !busy && !done && !fault && !memReqValid);

endmodule

// File: tb/test_bnd_walker.sv
module test_bnd_walker;

  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid, reqReady, reqStore, reqMode64;
  logic [1:0]  reqCpl;
  logic [63:0] reqBase, reqPtr, reqLower, reqUpper, cfgUser, cfgSuper;
  logic        busy, done, fault;
  logic [63:0] lowerOut, upperOut, status;
  logic        memReqValid, memReqReady, memReqWrite, memReqWide;
  logic [63:0] memReqAddr, memReqWdata;
  logic        memRspValid;
  logic [63:0] memRspData;

  always #10 clk = ~clk;

  bnd_walker i_bnd_walker (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqStore(reqStore), .reqMode64(reqMode64), .reqCpl(reqCpl),
    .reqBase(reqBase), .reqPtr(reqPtr), .reqLower(reqLower), .reqUpper(reqUpper),
    .cfgUser(cfgUser), .cfgSuper(cfgSuper), .busy(busy), .done(done),
    .fault(fault), .lowerOut(lowerOut), .upperOut(upperOut), .status(status),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqWrite(memReqWrite), .memReqWide(memReqWide),
    .memReqAddr(memReqAddr), .memReqWdata(memReqWdata),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Memory model state
  logic [63:0] memDir, memLo, memUp, memPt;
  int          stallSet;
  int          stallCnt;
  bit          pendingRsp;
  logic [63:0] pendingData;
  int          logCount;
  logic [63:0] logAddr  [8];
  logic        logWrite [8];
  logic        logWide  [8];
  logic [63:0] logWdata [8];

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Memory responder: one access at a time, optional ready stall
  initial begin
    memReqReady = 1'b0;
    memRspValid = 1'b0;
    memRspData  = '0;
    pendingRsp  = 0;
    forever begin
      @(negedge clk);
      memReqReady = 1'b0;
      memRspValid = 1'b0;
      if (pendingRsp) begin
        memRspValid = 1'b1;
        memRspData  = pendingData;
        pendingRsp  = 0;
      end else if (memReqValid) begin
        if (stallCnt > 0) begin
          stallCnt--;
        end else begin
          memReqReady = 1'b1;
          if (logCount < 8) begin
            logAddr[logCount]  = memReqAddr;
            logWrite[logCount] = memReqWrite;
            logWide[logCount]  = memReqWide;
            logWdata[logCount] = memReqWdata;
          end
          case (logCount)
            0:       pendingData = memDir;
            1:       pendingData = memLo;
            2:       pendingData = memUp;
            default: pendingData = memPt;
          endcase
          logCount++;
          pendingRsp = 1;
          stallCnt   = stallSet;
        end
      end
    end
  end

  function automatic logic [63:0] expDir(input bit m64, input logic [63:0] base,
                                         input logic [63:0] cfg);
    if (m64) return (((base >> 20) & 64'hFFF_FFFF) << 3) + ((cfg >> 20) << 12);
    return ((((base >> 12) & 64'hF_FFFF) << 2) + (cfg & 64'hFFFF_F000)) &
           64'hFFFF_FFFF;
  endfunction

  function automatic logic [63:0] expEnt(input bit m64, input logic [63:0] base,
                                         input logic [63:0] dir, input int k);
    if (m64) return (((base >> 3) & 64'h1_FFFF) << 5) + (dir & ~64'h7) + 64'(k * 8);
    return ((((base >> 2) & 64'h3FF) << 4) + (dir & 64'hFFFF_FFFC) + 64'(k * 4)) &
           64'hFFFF_FFFF;
  endfunction

  logic [63:0] seed = 64'h1234_5678_9ABC_DEF1;
  function automatic logic [63:0] nextRand();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed ^ (seed >> 29);
  endfunction

  // kind: 0 load match, 1 load mismatch, 2 store, 3 invalid directory,
  //       4 load with pointer differing only in bits 63:32
  task automatic runOp(input bit m64, input logic [1:0] cpl, input int kind,
                       input int stall);
    logic [63:0] cfgSel, dAddr, mask, dirUse, expLo, expUp;
    bit          isStore, match;
    int          waitCnt;
    mask     = m64 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF;
    reqBase  = nextRand();
    reqPtr   = nextRand();
    reqLower = nextRand();
    reqUpper = nextRand();
    cfgUser  = nextRand();
    cfgSuper = nextRand();
    memLo    = nextRand();
    memUp    = nextRand();
    memDir   = nextRand();
    memDir[0] = (kind != 3);
    case (kind)
      1:       memPt = reqPtr ^ 64'h10;
      4:       memPt = reqPtr ^ 64'h0100_0000_0000_0000;
      default: memPt = reqPtr;
    endcase
    isStore   = (kind == 2);
    reqStore  = isStore;
    reqMode64 = m64;
    reqCpl    = cpl;
    cfgSel    = (cpl == 2'd3) ? cfgUser : cfgSuper;
    dAddr     = expDir(m64, reqBase, cfgSel);
    dirUse    = memDir & mask;
    match     = ((memPt & mask) == (reqPtr & mask));
    stallSet  = stall;
    stallCnt  = stall;
    logCount  = 0;
    chk("R12", "reqReady before request", {63'b0, reqReady}, 64'd1);
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R11", "busy after accept", {63'b0, busy}, 64'd1);
    waitCnt = 0;
    while (!(done || fault) && waitCnt < 200) begin
      chk("R11", "busy during walk", {63'b0, busy}, 64'd1);
      @(negedge clk);
      waitCnt++;
    end
    chk("R11", "walk completes", {63'b0, (waitCnt < 200)}, 64'd1);
    chk(m64 ? "R2" : "R3", "directory address", logAddr[0], dAddr);
    chk(m64 ? "R2" : "R3", "directory width", {63'b0, logWide[0]}, {63'b0, m64});
    chk(m64 ? "R2" : "R3", "directory is read", {63'b0, logWrite[0]}, 64'd0);
    chk("R1", "config source via directory address", logAddr[0],
        expDir(m64, reqBase, (cpl == 2'd3) ? cfgUser : cfgSuper));
    if (kind == 3) begin
      chk("R4", "fault pulse", {63'b0, fault}, 64'd1);
      chk("R4", "done low on fault", {63'b0, done}, 64'd0);
      chk("R4", "status value", status, dAddr | 64'd2);
      chk("R4", "no table access", 64'(logCount), 64'd1);
    end else begin
      chk("R11", "done pulse", {63'b0, done}, 64'd1);
      chk("R11", "fault low on success", {63'b0, fault}, 64'd0);
      chk("R10", "access count", 64'(logCount), 64'd4);
      for (int k = 0; k < 3; k++) begin
        chk(m64 ? "R5" : "R6", "field address", logAddr[k+1],
            expEnt(m64, reqBase, dirUse, k));
        chk(m64 ? "R5" : "R6", "field width", {63'b0, logWide[k+1]}, {63'b0, m64});
        chk(isStore ? "R9" : "R7", "field direction", {63'b0, logWrite[k+1]},
            {63'b0, isStore});
      end
      if (isStore) begin
        chk("R9", "store lower first", logWdata[1], reqLower & mask);
        chk("R9", "store upper second", logWdata[2], reqUpper & mask);
        chk("R9", "store pointer third", logWdata[3], reqPtr & mask);
      end else begin
        expLo = match ? (memLo & mask) : 64'd0;
        expUp = match ? (memUp & mask) : 64'd0;
        chk(match ? "R7" : "R8", "lower bound", lowerOut, expLo);
        chk(match ? "R7" : "R8", "upper bound", upperOut, expUp);
        if (kind == 4)
          chk(m64 ? "R8" : "R6", "high-half pointer difference",
              {63'b0, match}, {63'b0, !m64});
      end
    end
    @(negedge clk);
    chk("R11", "pulse is single cycle", {62'b0, done, fault}, 64'd0);
    chk("R11", "idle after finish", {63'b0, busy}, 64'd0);
  endtask

  initial begin
    rst       = 1'b1;
    reqValid  = 1'b0;
    reqStore  = 1'b0;
    reqMode64 = 1'b0;
    reqCpl    = 2'd0;
    reqBase   = '0;
    reqPtr    = '0;
    reqLower  = '0;
    reqUpper  = '0;
    cfgUser   = '0;
    cfgSuper  = '0;
    memDir    = '0;
    memLo     = '0;
    memUp     = '0;
    memPt     = '0;
    stallSet  = 0;
    stallCnt  = 0;
    logCount  = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R12", "reset status", status, 64'd0);
    chk("R12", "reset idle", {61'b0, reqReady, busy, done}, 64'b100);
    chk("R12", "reset fault/mem", {62'b0, fault, memReqValid}, 64'd0);
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 4; c++)
        for (int kd = 0; kd < 5; kd++)
          runOp(m[0], c[1:0], kd, (m + c + kd) % 3);
    // Status persists the last fault address; new fault overwrites it
    runOp(1'b1, 2'd3, 3, 0);
    runOp(1'b0, 2'd0, 3, 2);
    // Reset mid-walk clears status and returns to idle
    reqValid = 1'b1; reqMode64 = 1'b1; reqStore = 1'b0;
    stallSet = 5; stallCnt = 5; logCount = 0;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    stallSet = 0; stallCnt = 0;
    chk("R12", "status cleared by reset", status, 64'd0);
    chk("R12", "idle after mid-walk reset", {62'b0, reqReady, busy}, 64'b10);
    repeat (3) @(negedge clk);
    runOp(1'b1, 2'd1, 0, 1);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R11 watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule